// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether an incoming Ethernet frame is kept, based only on its destination address. Software programs a table of station addresses, a per-entry enable mask and a small set of mode bits through a write-only register port. The receive path presents the six destination bytes with a one-cycle strobe. One clock later the block reports a verdict: accept or reject, whether a table entry hit, and which entry hit.

Each destination is first classed as broadcast (all six bytes 0xFF), multicast (least significant bit of byte 0 set, not broadcast) or unicast (that bit clear). The class is weighed against the accept-all mode bits, and in parallel against every enabled table entry. A table hit only counts when the compare-enable mode bit is set. When several entries match, the lowest index wins.

A two-state machine sequences the verdict. In ST_WAIT no verdict is shown. The transition WAIT_TO_VERDICT fires on a strobe. In ST_VERDICT the registered result is shown for exactly one cycle. From there, VERDICT_TO_VERDICT fires on a back-to-back strobe and VERDICT_TO_WAIT fires when no strobe follows. WAIT_TO_WAIT holds the idle state.

Top module: `dafilt_top`

## Requirements
- R1: After reset all table entries, the enable mask and the mode bits are zero, `res_valid` is low, and a strobed address is rejected with `res_hit` low.
- R2: Entry i is written as two words. At byte offset 0x08+8*i, bits 31:24 hold address byte 0 down to bits 7:0 holding byte 3. At offset 0x0C+8*i, bits 31:24 hold byte 4 and bits 23:16 hold byte 5; bits 15:0 of that word are ignored. Address byte 0 is `rx_da[47:40]`.
- R3: The enable word at offset 0x04 has bit i enabling entry i; a disabled entry never produces a hit.
- R4: Mode word (offset 0x00) bit 4 enables table comparison; with it clear, `res_hit` is low and table contents do not cause acceptance.
- R5: Mode bit 0 accepts every unicast destination (`rx_da[40]` = 0).
- R6: Mode bit 1 accepts every multicast destination (`rx_da[40]` = 1 and not all-ones).
- R7: Mode bit 2 accepts broadcast (all 48 bits set); a broadcast is not accepted by bit 1 alone.
- R8: When several enabled entries match, `res_idx` is the lowest matching index; with no hit `res_idx` is 0.
- R9: `res_valid` is high in exactly the cycle after each cycle in which `rx_strobe` is high, including back-to-back strobes. Outside those cycles `res_accept` and `res_hit` are low.
- R10: A register write in the same cycle as a strobe does not affect that verdict and applies from the next strobe onward.
- R11: Mode value 0x17 accepts every destination; mode value 0x14 accepts broadcast and table hits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| rx_strobe | input | 1 | Destination address valid, one cycle per frame |
| rx_da | input | 48 | Destination address, byte 0 in bits 47:40 |
| res_valid | output | 1 | Verdict valid |
| res_accept | output | 1 | Frame accepted |
| res_hit | output | 1 | An enabled table entry matched with comparison on |
| res_idx | output | $clog2(N_ENTRY) (4) | Lowest matching entry index |

## Verification
The bench builds the block with its defaults: sixteen entries and an eight-bit register offset. This puts the last entry's words at 0x80 and 0x84, so the stride arithmetic is exercised at both ends of the table. With sixteen entries the priority check can place duplicate addresses in the middle of the table and then remove the lower one. A four-bit index also lets every index value show up at the port.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    typedef struct packed {
        logic cmp_en;
        logic acc_bc;
        logic acc_mc;
        logic acc_uc;
    } mode_t;

    typedef struct packed {
        logic bc;
        logic mc;
        logic uc;
    } da_class_t;

    typedef enum logic [0:0] {
        ST_WAIT    = 1'b0,
        ST_VERDICT = 1'b1
    } vstate_t;

    function automatic da_class_t classify(input logic [47:0] da);
        da_class_t c;
        c.bc = &da;
        c.mc = da[40] & ~c.bc;
        c.uc = ~da[40];
        return c;
    endfunction

endpackage

// File: rtl/dafilt_regs.sv
module dafilt_regs
    import dafilt_pkg::*;
#(
    parameter int N_ENTRY = 16,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    output mode_t              mode_q,
    output logic [N_ENTRY-1:0] ent_en_q,
    output logic [47:0]        ent_mac_q [N_ENTRY]
);

    localparam int MODE_OFF = 0;
    localparam int EN_OFF   = 4;
    localparam int ENT_BASE = 8;
    localparam int STRIDE   = 8;

    logic mode_sel;
    logic en_sel;

    assign mode_sel = wr_en && (wr_addr == ADDR_W'(MODE_OFF));
    assign en_sel   = wr_en && (wr_addr == ADDR_W'(EN_OFF));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_sel) begin
            mode_q.cmp_en <= wr_data[4];
            mode_q.acc_bc <= wr_data[2];
            mode_q.acc_mc <= wr_data[1];
            mode_q.acc_uc <= wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_en_q <= '0;
        end else if (en_sel) begin
            ent_en_q <= wr_data[N_ENTRY-1:0];
        end
    end

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
        localparam int HI_OFF = ENT_BASE + STRIDE * g;
        localparam int LO_OFF = HI_OFF + 4;

        logic hi_sel;
        logic lo_sel;

        assign hi_sel = wr_en && (wr_addr == ADDR_W'(HI_OFF));
        assign lo_sel = wr_en && (wr_addr == ADDR_W'(LO_OFF));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_mac_q[g] <= '0;
            end else begin
                if (hi_sel) ent_mac_q[g][47:16] <= wr_data;
                if (lo_sel) ent_mac_q[g][15:0]  <= wr_data[31:16];
            end
        end
    end

endmodule

// File: rtl/dafilt_match.sv
module dafilt_match #(
    parameter int N_ENTRY = 16,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic [47:0]        da,
    input  logic [N_ENTRY-1:0] ent_en,
    input  logic [47:0]        ent_mac [N_ENTRY],
    output logic               any_hit,
    output logic [IDX_W-1:0]   hit_idx
);

    logic [N_ENTRY-1:0] eq;

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
        assign eq[g] = ent_en[g] && (ent_mac[g] == da);
    end

    assign any_hit = |eq;

    always_comb begin
        hit_idx = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
    import dafilt_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  da_class_t        cls,
    input  mode_t            mode,
    input  logic             any_hit,
    input  logic [IDX_W-1:0] hit_idx,
    output logic             res_valid,
    output logic             res_accept,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx
);

    vstate_t state_q;
    vstate_t state_d;

    logic             tbl_hit;
    logic             cls_acc;

    assign tbl_hit = mode.cmp_en & any_hit;
    assign cls_acc = (cls.uc & mode.acc_uc) |
                     (cls.mc & mode.acc_mc) |
                     (cls.bc & mode.acc_bc);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:    state_d = strobe ? ST_VERDICT : ST_WAIT;
            ST_VERDICT: state_d = strobe ? ST_VERDICT : ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_accept <= 1'b0;
            res_hit    <= 1'b0;
            res_idx    <= '0;
        end else if (strobe) begin
            res_accept <= cls_acc | tbl_hit;
            res_hit    <= tbl_hit;
            res_idx    <= tbl_hit ? hit_idx : '0;
        end else begin
            res_accept <= 1'b0;
            res_hit    <= 1'b0;
            res_idx    <= '0;
        end
    end

    assign res_valid = (state_q == ST_VERDICT);

endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
    import dafilt_pkg::*;
#(
    parameter int N_ENTRY = 16,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              rx_strobe,
    input  logic [47:0]       rx_da,
    output logic              res_valid,
    output logic              res_accept,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_idx
);

    mode_t              mode_q;
    logic [N_ENTRY-1:0] ent_en_q;
    logic [47:0]        ent_mac_q [N_ENTRY];
    logic               any_hit;
    logic [IDX_W-1:0]   hit_idx;
    da_class_t          cls;

    assign cls = classify(rx_da);

    dafilt_regs #(.N_ENTRY(N_ENTRY), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .mode_q   (mode_q),
        .ent_en_q (ent_en_q),
        .ent_mac_q(ent_mac_q)
    );

    dafilt_match #(.N_ENTRY(N_ENTRY)) u_match (
        .da     (rx_da),
        .ent_en (ent_en_q),
        .ent_mac(ent_mac_q),
        .any_hit(any_hit),
        .hit_idx(hit_idx)
    );

    dafilt_decide #(.IDX_W(IDX_W)) u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (rx_strobe),
        .cls       (cls),
        .mode      (mode_q),
        .any_hit   (any_hit),
        .hit_idx   (hit_idx),
        .res_valid (res_valid),
        .res_accept(res_accept),
        .res_hit   (res_hit),
        .res_idx   (res_idx)
    );

endmodule

// File: rtl/dafilt_chk.sv
module dafilt_chk
    import dafilt_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_strobe,
    input logic [47:0]      rx_da,
    input mode_t            mode,
    input logic             res_valid,
    input logic             res_accept,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_idx
);

    // R9
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> res_valid);

    // R9
    quiet_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |=> !res_valid);

    // R9
    idle_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_accept && !res_hit));

    // R4
    hit_needs_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !mode.cmp_en) |=> !res_hit);

    // R4
    hit_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_accept);

    // R7
    bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && (&rx_da) && mode.acc_bc) |=> res_accept);

    // R5
    ucast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !rx_da[40] && mode.acc_uc) |=> res_accept);

    // R8
    idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_idx == '0));

endmodule

bind dafilt_top dafilt_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_strobe (rx_strobe),
    .rx_da     (rx_da),
    .mode      (mode_q),
    .res_valid (res_valid),
    .res_accept(res_accept),
    .res_hit   (res_hit),
    .res_idx   (res_idx)
);

// File: tb/dafilt_top_test.sv
module dafilt_top_test;

    localparam int N  = 16;
    localparam int AW = 8;
    localparam int IW = 4;

    typedef struct {
        logic          acc;
        logic          hit;
        logic [IW-1:0] idx;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          rx_strobe = 1'b0;
    logic [47:0]   rx_da = '0;
    logic          res_valid;
    logic          res_accept;
    logic          res_hit;
    logic [IW-1:0] res_idx;

    int checks = 0;
    int fails  = 0;

    logic [4:0]   sh_cmd = '0;
    logic [N-1:0] sh_en  = '0;
    logic [47:0]  sh_mac [N];

    exp_t q [$];

    always #10ns clk = ~clk;

    dafilt_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rx_strobe(rx_strobe), .rx_da(rx_da),
        .res_valid(res_valid), .res_accept(res_accept), .res_hit(res_hit),
        .res_idx(res_idx)
    );

    function automatic void check(bit ok, string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endfunction

    function automatic exp_t predict(logic [47:0] da, string tag);
        exp_t e;
        bit bc;
        bit mc;
        bit uc;
        bc = &da;
        mc = da[40] && !bc;
        uc = !da[40];
        e.hit = 1'b0;
        e.idx = '0;
        e.tag = tag;
        if (sh_cmd[4]) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (sh_en[i] && sh_mac[i] == da) begin
                    e.hit = 1'b1;
                    e.idx = i[IW-1:0];
                end
            end
        end
        e.acc = (uc && sh_cmd[0]) || (mc && sh_cmd[1]) || (bc && sh_cmd[2]) || e.hit;
        return e;
    endfunction

    function automatic void shadow_write(logic [AW-1:0] a, logic [31:0] d);
        if (a == 8'h00) sh_cmd = d[4:0] & 5'h17;
        else if (a == 8'h04) sh_en = d[N-1:0];
        for (int i = 0; i < N; i++) begin
            if (a == AW'(8 + 8 * i))  sh_mac[i][47:16] = d;
            if (a == AW'(12 + 8 * i)) sh_mac[i][15:0]  = d[31:16];
        end
    endfunction

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        shadow_write(a, d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_entry(int i, logic [47:0] mac);
        wr(AW'(8 + 8 * i), mac[47:16]);
        wr(AW'(12 + 8 * i), {mac[15:0], 16'hBEEF});
    endtask

    task automatic send(logic [47:0] da, string tag);
        @(negedge clk);
        rx_da = da; rx_strobe = 1'b1;
        q.push_back(predict(da, tag));
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    task automatic send_pair(logic [47:0] a, logic [47:0] b, string tag);
        @(negedge clk);
        rx_da = a; rx_strobe = 1'b1;
        q.push_back(predict(a, tag));
        @(negedge clk);
        rx_da = b;
        q.push_back(predict(b, tag));
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    task automatic write_and_send(logic [AW-1:0] a, logic [31:0] d, logic [47:0] da, string tag);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        rx_da = da; rx_strobe = 1'b1;
        q.push_back(predict(da, tag));
        shadow_write(a, d);
        @(negedge clk);
        reg_wr = 1'b0; rx_strobe = 1'b0;
    endtask

    task automatic check_quiet(string tag);
        repeat (2) @(negedge clk);
        check(res_valid == 1'b0 && res_accept == 1'b0,
              $sformatf("%s: idle valid=%0b accept=%0b, expected 0 0", tag, res_valid, res_accept));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (q.size() == 0) begin
                check(1'b0, $sformatf("R9: valid=%0b with no strobe outstanding, expected 0", res_valid));
            end else begin
                exp_t e;
                e = q.pop_front();
                check(res_accept == e.acc && res_hit == e.hit && res_idx == e.idx,
                      $sformatf("%s: acc=%0b hit=%0b idx=%0d, expected acc=%0b hit=%0b idx=%0d",
                                e.tag, res_accept, res_hit, res_idx, e.acc, e.hit, e.idx));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    localparam logic [47:0] MAC_A = 48'h0A1B2C3D4E5F;
    localparam logic [47:0] MAC_B = 48'h02C0FFEE0042;
    localparam logic [47:0] MAC_C = 48'h105566778899;
    localparam logic [47:0] UC_X  = 48'h00DEADBEEF01;
    localparam logic [47:0] MC_X  = 48'h01005E000001;
    localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;

    initial begin
        for (int i = 0; i < N; i++) sh_mac[i] = '0;
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0 && res_accept == 1'b0 && res_hit == 1'b0,
              $sformatf("R1 reset outputs: %0b%0b%0b, expected 000", res_valid, res_accept, res_hit));
        rst_n = 1'b1;

        // R1: cleared state rejects everything
        send(UC_X, "R1 zero table unicast");
        send(BCAST, "R1 zero table broadcast");
        check_quiet("R9 quiet after single strobe");

        // R2/R3: programmed but disabled, then enabled
        wr(8'h00, 32'h10);
        set_entry(0, MAC_A);
        send(MAC_A, "R3 disabled entry no hit");
        wr(8'h04, 32'h0001);
        send(MAC_A, "R2 entry 0 hit");
        send(MAC_A ^ 48'h1, "R2 low bits differ");

        // R4: compare disabled
        wr(8'h00, 32'h00);
        send(MAC_A, "R4 compare off");

        // R2 stride at last entry, R8 priority
        wr(8'h00, 32'h10);
        set_entry(15, MAC_B);
        set_entry(5, MAC_C);
        set_entry(9, MAC_C);
        wr(8'h04, 32'h8221);
        send(MAC_B, "R2 entry 15 hit");
        send(MAC_C, "R8 lowest of 5 and 9");
        wr(8'h04, 32'h8201);
        send(MAC_C, "R3 entry 5 disabled -> 9");

        // R5
        wr(8'h00, 32'h01);
        send(UC_X, "R5 unicast accepted");
        send(MC_X, "R5 multicast not accepted");
        // R6
        wr(8'h00, 32'h02);
        send(MC_X, "R6 multicast accepted");
        send(BCAST, "R7 broadcast not multicast");
        send(UC_X, "R6 unicast not accepted");
        // R7
        wr(8'h00, 32'h04);
        send(BCAST, "R7 broadcast accepted");
        send(MC_X, "R7 multicast not accepted");

        // R11 normal and promiscuous
        wr(8'h00, 32'h14);
        send(UC_X, "R11 normal rejects unknown");
        send(BCAST, "R11 normal accepts broadcast");
        send(MAC_A, "R11 normal accepts hit");
        send(MC_X, "R11 normal rejects multicast");
        wr(8'h00, 32'h17);
        send(UC_X, "R11 promisc unicast");
        send(MC_X, "R11 promisc multicast");
        send(MAC_B, "R11 promisc hit 15");

        // R9 back-to-back strobes
        send_pair(MAC_C, UC_X, "R9 back-to-back");
        check_quiet("R9 quiet after pair");

        // R10 write during compare
        wr(8'h00, 32'h14);
        write_and_send(8'h04, 32'h0000, MAC_A, "R10 old enable used");
        send(MAC_A, "R10 new enable applied");
        write_and_send(8'h00, 32'h01, UC_X, "R10 old mode used");
        send(UC_X, "R10 new mode applied");

        repeat (4) @(negedge clk);
        check(q.size() == 0, $sformatf("R9 outstanding verdicts %0d, expected 0", q.size()));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule